// File: doc/BRIEF.md
# CAN Controller Global Mode Register

This block is the global mode control register of a CAN controller. The CPU reaches it through a simple register port made of a write strobe, a 16-bit write word and a 16-bit read word. The block holds four things: the operation mode, the power-save mode and two single-bit flags, the arbitration-lost flag and the error-counter-clear flag. It drives the current operation mode and power-save mode to the protocol engine.

A write does not load fields directly. Every field bit has its own set bit and its own clear bit in the write word. The block merges the write with the held state and then checks the result against the allowed transitions. The block keeps a sleep request pending until the protocol engine reports an idle bus. Stop mode can only be entered from sleep and left to sleep. The operation mode cannot change while the controller is asleep or stopped. A read always returns the state that is actually in effect, and a busy bit shows that a requested change has not yet completed.

Top module: `can_mode_ctrl`

## Requirements
- R1: After a synchronous reset the operation mode reads 000 and the power-save mode reads 00. The arbitration-lost flag, the error-counter-clear flag and the busy bit all read 0.
- R2: Write word layout: bits 6:0 are clear bits and bits 14:8 are set bits for field bits 6:0. Field bits are: operation mode at 2:0, power-save mode at 4:3, arbitration-lost at 5, error-counter-clear at 6. For each field bit, set=1 with clear=0 requests 1, clear=1 with set=0 requests 0, and any other pair keeps the current value. An operation-mode request of 000 to 101 takes effect on the next clock edge when the power-save mode is 00.
- R3: A merged operation-mode request of 110 or 111 is discarded and the previous mode is kept.
- R4: While the power-save mode is 01 (sleep) or 11 (stop), writes leave the operation mode unchanged.
- R5: A merged power-save request of 10 is discarded.
- R6: A write requesting 01 while the power-save mode is 00 makes the request pending. While it is pending the busy bit reads 1 and the power-save mode stays 00. The first cycle on which bus_idle is high completes the request: after that edge the power-save mode reads 01 and the busy bit reads 0.
- R7: A write that touches the power-save bits and requests 00 while a sleep request is pending cancels it. This holds even if bus_idle is high in the same cycle. The power-save mode stays 00 and the busy bit drops to 0.
- R8: Stop mode (11) is entered only from sleep and is left only to sleep. A request for 11 from 00, or for 00 from 11, is ignored.
- R9: A request for 00 while in sleep returns the power-save mode to 00 on the next edge.
- R10: Arbitration-lost flag: set=1 with clear=0 sets it, clear=1 with set=0 clears it, and any other pair leaves it unchanged.
- R11: Error-counter-clear flag: set=1 with clear=0 sets it. No other write combination changes it; only reset clears it.
- R12: Read word layout: operation mode at bits 2:0, power-save mode at 4:3, arbitration-lost at 5, error-counter-clear at 6, busy at 7, and bits 15:8 read 0. Write bits 7 and 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write word: clear bits 6:0, set bits 14:8 |
| rd_data | output | 16 | Read word showing the mode in effect |
| bus_idle | input | 1 | One-cycle bus-idle pulse from the protocol engine |
| op_mode | output | 3 | Operation mode in effect |
| ps_mode | output | 2 | Power-save mode in effect |
| al_flag | output | 1 | Arbitration-lost flag |
| ccerc_flag | output | 1 | Error-counter-clear flag |
| mode_busy | output | 1 | A sleep request is pending |

## Verification
The assertions assume that reset is held low through the first clock edge and that wr_en and wr_data hold steady around each rising edge. They also assume that bus_idle is a plain level sampled at the edge; it need not be a single pulse. The stimulus drives all inputs on the falling edge, so every value is stable at the sampling edge. The fixed-seed random phase covers the awkward cases: pairs with both set and clear high, bus_idle arriving in the same cycle as a cancel or a new request, and prohibited codes. None of these breaks an assumption.

// File: rtl/can_mode_pkg.sv
// Package: field positions, widths and mode codes shared by the mode register.
// Assumes the field layout of the write and read words is fixed by R2 and R12.
package can_mode_pkg;
    localparam int OP_W     = 3;
    localparam int PS_W     = 2;
    localparam int FIELD_W  = 7;
    localparam int OP_LSB   = 0;
    localparam int PS_LSB   = 3;
    localparam int AL_BIT   = 5;
    localparam int CC_BIT   = 6;
    localparam int BUSY_BIT = 7;
    localparam int SET_OFS  = 8;

    localparam logic [OP_W-1:0] OP_INIT = 3'd0;
    localparam logic [OP_W-1:0] OP_LAST = 3'd5;

    localparam logic [PS_W-1:0] PS_NONE  = 2'b00;
    localparam logic [PS_W-1:0] PS_SLEEP = 2'b01;
    localparam logic [PS_W-1:0] PS_BAD   = 2'b10;
    localparam logic [PS_W-1:0] PS_STOP  = 2'b11;
endpackage

// File: rtl/can_mode_pair_merge.sv
// Merges a set/clear bit pair into the current value of a field, one bit at a time.
// Assumes nothing about the caller; purely combinational.
module can_mode_pair_merge #(
    parameter int W = 1
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] val_o,
    output logic         touched_o
);
    // one merge cell for each field bit
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign val_o[b] = (set_i[b] & ~clr_i[b]) ? 1'b1 :
                          (clr_i[b] & ~set_i[b]) ? 1'b0 : cur_i[b];
    end

    assign touched_o = |(set_i | clr_i);
endmodule

// File: rtl/can_mode_opmode.sv
// Holds the operation mode and accepts a merged request only when it is a legal
// code and the controller is awake. Assumes lock_i comes from a register.
module can_mode_opmode
    import can_mode_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [OP_W-1:0] req_i,
    input  logic            lock_i,
    output logic [OP_W-1:0] op_o
);
    logic [OP_W-1:0] op_q;
    logic            take;

    // accept only legal codes while not in a power-save mode
    assign take = wr_en && !lock_i && (req_i <= OP_LAST);

    // operation mode register
    always_ff @(posedge clk) begin
        if (!rst_n)    op_q <= OP_INIT;
        else if (take) op_q <= req_i;
    end

    assign op_o = op_q;

    // R3
    op_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_q <= OP_LAST);

    // R4
    op_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> $stable(op_q));

    // R2
    op_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !lock_i && req_i <= OP_LAST) |=> (op_q == $past(req_i)));
endmodule

// File: rtl/can_mode_pwrsave.sv
// Power-save state machine: pending sleep, sleep, stop and wake transitions.
// Assumes bus_idle_i is synchronous; touched_i marks writes that address the field.
module can_mode_pwrsave
    import can_mode_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            touched_i,
    input  logic [PS_W-1:0] req_i,
    input  logic            bus_idle_i,
    output logic [PS_W-1:0] ps_o,
    output logic            pend_o
);
    logic [PS_W-1:0] ps_q, ps_n;
    logic            pend_q, pend_n;
    logic            cancel;

    // next-state of power-save mode and pending sleep request
    always_comb begin
        ps_n   = ps_q;
        pend_n = pend_q;
        cancel = 1'b0;
        if (wr_en && touched_i && req_i != PS_BAD) begin
            case (ps_q)
                PS_NONE: begin
                    if (req_i == PS_SLEEP) begin
                        pend_n = 1'b1;
                    end else if (req_i == PS_NONE) begin
                        pend_n = 1'b0;
                        cancel = pend_q;
                    end
                end
                PS_SLEEP: begin
                    if (req_i == PS_NONE)      ps_n = PS_NONE;
                    else if (req_i == PS_STOP) ps_n = PS_STOP;
                end
                PS_STOP: begin
                    if (req_i == PS_SLEEP) ps_n = PS_SLEEP;
                end
                default: ps_n = ps_q;
            endcase
        end
        if (pend_q && bus_idle_i && !cancel) begin
            ps_n   = PS_SLEEP;
            pend_n = 1'b0;
        end
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q   <= PS_NONE;
            pend_q <= 1'b0;
        end else begin
            ps_q   <= ps_n;
            pend_q <= pend_n;
        end
    end

    assign ps_o   = ps_q;
    assign pend_o = pend_q;

    // R5
    ps_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ps_q != PS_BAD);

    // R8
    stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ps_q) == PS_NONE) |-> (ps_q != PS_STOP));

    // R8
    stop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ps_q) == PS_STOP) |-> (ps_q != PS_NONE));

    // R6
    sleep_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && bus_idle_i && !cancel) |=> (ps_q == PS_SLEEP && !pend_q));

    // R6
    pend_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> (ps_q == PS_NONE));

    // R7
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> (!pend_q && ps_q == PS_NONE));
endmodule

// File: rtl/can_mode_ctrl.sv
// Global mode register of a CAN controller: decodes set/clear writes, holds the
// flags and composes the read word. Assumes one register and a synchronous bus.
module can_mode_ctrl
    import can_mode_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              bus_idle,
    output logic [OP_W-1:0]   op_mode,
    output logic [PS_W-1:0]   ps_mode,
    output logic              al_flag,
    output logic              ccerc_flag,
    output logic              mode_busy
);
    localparam int RD_USED = BUSY_BIT + 1;

    logic [FIELD_W-1:0] clr_v, set_v;
    logic [OP_W-1:0]    op_req, op_q;
    logic [PS_W-1:0]    ps_req, ps_q;
    logic               op_touch, ps_touch;
    logic               pend_q, al_q, cc_q;

    assign clr_v = wr_data[FIELD_W-1:0];
    assign set_v = wr_data[SET_OFS +: FIELD_W];

    can_mode_pair_merge #(.W(OP_W)) i_op_merge (
        .cur_i(op_q), .set_i(set_v[OP_LSB +: OP_W]), .clr_i(clr_v[OP_LSB +: OP_W]),
        .val_o(op_req), .touched_o(op_touch)
    );

    can_mode_pair_merge #(.W(PS_W)) i_ps_merge (
        .cur_i(ps_q), .set_i(set_v[PS_LSB +: PS_W]), .clr_i(clr_v[PS_LSB +: PS_W]),
        .val_o(ps_req), .touched_o(ps_touch)
    );

    can_mode_opmode i_opmode (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .req_i(op_req),
        .lock_i(ps_q != PS_NONE), .op_o(op_q)
    );

    can_mode_pwrsave i_pwrsave (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .touched_i(ps_touch),
        .req_i(ps_req), .bus_idle_i(bus_idle), .ps_o(ps_q), .pend_o(pend_q)
    );

    // arbitration-lost flag: set/clear pair, ambiguous pairs hold
    always_ff @(posedge clk) begin
        if (!rst_n) al_q <= 1'b0;
        else if (wr_en && set_v[AL_BIT] && !clr_v[AL_BIT]) al_q <= 1'b1;
        else if (wr_en && clr_v[AL_BIT] && !set_v[AL_BIT]) al_q <= 1'b0;
    end

    // error-counter-clear flag: software may only set it
    always_ff @(posedge clk) begin
        if (!rst_n) cc_q <= 1'b0;
        else if (wr_en && set_v[CC_BIT] && !clr_v[CC_BIT]) cc_q <= 1'b1;
    end

    // read word built from state in effect
    always_comb begin
        rd_data = '0;
        rd_data[OP_LSB +: OP_W] = op_q;
        rd_data[PS_LSB +: PS_W] = ps_q;
        rd_data[AL_BIT]         = al_q;
        rd_data[CC_BIT]         = cc_q;
        rd_data[BUSY_BIT]       = pend_q;
    end

    assign op_mode    = op_q;
    assign ps_mode    = ps_q;
    assign al_flag    = al_q;
    assign ccerc_flag = cc_q;
    assign mode_busy  = pend_q;

    // R10
    al_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && set_v[AL_BIT] && !clr_v[AL_BIT]) |=> al_q);

    // R10
    al_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && clr_v[AL_BIT] && !set_v[AL_BIT]) |=> !al_q);

    // R11
    cc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(cc_q));

    // R12
    rd_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:RD_USED] == '0);
endmodule

// File: tb/test_can_mode_ctrl.sv
// Bench: directed corner cases then fixed-seed random writes, checked against a
// reference model kept in bench functions.
module test_can_mode_ctrl;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        bus_idle = 1'b0;
    logic [15:0] rd_data;
    logic [2:0]  op_mode;
    logic [1:0]  ps_mode;
    logic        al_flag, ccerc_flag, mode_busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [2:0] m_op;
    logic [1:0] m_ps;
    logic       m_pend, m_al, m_cc;

    can_mode_ctrl i_can_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .bus_idle(bus_idle), .op_mode(op_mode),
        .ps_mode(ps_mode), .al_flag(al_flag), .ccerc_flag(ccerc_flag),
        .mode_busy(mode_busy)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [6:0] merge7(logic [6:0] cur, logic [6:0] s, logic [6:0] c);
        logic [6:0] r;
        for (int b = 0; b < 7; b++)
            r[b] = (s[b] && !c[b]) ? 1'b1 : (c[b] && !s[b]) ? 1'b0 : cur[b];
        return r;
    endfunction

    function automatic logic [15:0] exp_rd();
        return {8'h00, m_pend, m_cc, m_al, m_ps, m_op};
    endfunction

    // advance the reference model by one clock edge
    task automatic model_step(logic we, logic [15:0] d, logic idle);
        logic [6:0] s, c, mv;
        logic [2:0] n_op;
        logic [1:0] n_ps, rq;
        logic       n_pend, canc;
        s = d[14:8]; c = d[6:0];
        mv = merge7({m_cc, m_al, m_ps, m_op}, s, c);
        n_op = m_op; n_ps = m_ps; n_pend = m_pend; canc = 1'b0;
        if (we) begin
            if (m_ps == 2'b00 && mv[2:0] <= 3'd5) n_op = mv[2:0];
            rq = mv[4:3];
            if ((|(s[4:3] | c[4:3])) && rq != 2'b10) begin
                if (m_ps == 2'b00) begin
                    if (rq == 2'b01) n_pend = 1'b1;
                    else if (rq == 2'b00) begin n_pend = 1'b0; canc = m_pend; end
                end else if (m_ps == 2'b01) begin
                    if (rq != 2'b01) n_ps = rq;
                end else if (rq == 2'b01) n_ps = 2'b01;
            end
            if (s[5] && !c[5]) m_al = 1'b1;
            else if (c[5] && !s[5]) m_al = 1'b0;
            if (s[6] && !c[6]) m_cc = 1'b1;
        end
        if (m_pend && idle && !canc) begin n_ps = 2'b01; n_pend = 1'b0; end
        m_op = n_op; m_ps = n_ps; m_pend = n_pend;
    endtask

    task automatic check(string tag);
        logic [15:0] e;
        e = exp_rd();
        checks++;
        if (rd_data !== e || op_mode !== m_op || ps_mode !== m_ps ||
            al_flag !== m_al || ccerc_flag !== m_cc || mode_busy !== m_pend) begin
            fails++;
            $display("FAIL %s: rd_data=%h op=%0d ps=%0d al=%b cc=%b busy=%b expected rd_data=%h",
                     tag, rd_data, op_mode, ps_mode, al_flag, ccerc_flag, mode_busy, e);
        end
    endtask

    // drive at falling edge, model at rising edge, check at next falling edge
    task automatic step(logic we, logic [15:0] d, logic idle, string tag);
        wr_en = we; wr_data = d; bus_idle = idle;
        @(posedge clk);
        model_step(we, d, idle);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; bus_idle = 1'b0;
        check(tag);
    endtask

    function automatic logic [15:0] wd(logic [6:0] s, logic [6:0] c);
        return {1'b0, s, 1'b0, c};
    endfunction

    initial begin
        m_op = 3'd0; m_ps = 2'b00; m_pend = 1'b0; m_al = 1'b0; m_cc = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state");

        step(1, wd(7'h01, 7'h06), 0, "R2 op to normal");
        step(1, wd(7'h06, 7'h01), 0, "R3 op code 110 discarded");
        step(1, wd(7'h07, 7'h00), 0, "R3 op code 111 discarded");
        step(1, wd(7'h05, 7'h02), 0, "R2 op to self-test");
        step(1, wd(7'h10, 7'h08), 0, "R5 ps code 10 discarded");
        step(1, wd(7'h18, 7'h00), 0, "R8 stop from none ignored");
        step(1, wd(7'h08, 7'h00), 0, "R6 sleep pending");
        step(0, 16'h0000, 0, "R6 still pending without idle");
        step(1, wd(7'h00, 7'h08), 1, "R7 cancel beats idle");
        step(1, wd(7'h08, 7'h00), 0, "R6 sleep request again");
        step(0, 16'h0000, 1, "R6 sleep entered on idle");
        step(1, wd(7'h03, 7'h04), 0, "R4 op frozen in sleep");
        step(1, wd(7'h10, 7'h00), 0, "R8 sleep to stop");
        step(1, wd(7'h02, 7'h05), 0, "R4 op frozen in stop");
        step(1, wd(7'h00, 7'h18), 0, "R8 stop to none ignored");
        step(1, wd(7'h00, 7'h10), 0, "R8 stop to sleep");
        step(1, wd(7'h00, 7'h08), 0, "R9 sleep to none");
        step(1, wd(7'h20, 7'h00), 0, "R10 al set");
        step(1, wd(7'h20, 7'h20), 0, "R10 al both high holds");
        step(1, wd(7'h00, 7'h20), 0, "R10 al clear");
        step(1, wd(7'h40, 7'h00), 0, "R11 ccerc set");
        step(1, wd(7'h00, 7'h40), 0, "R11 ccerc clear ignored");
        step(1, 16'h8080, 0, "R12 bits 7 and 15 ignored");

        void'($urandom(32'd1234));
        for (int i = 0; i < 600; i++) begin
            logic [15:0] d;
            d = $urandom;
            step(($urandom % 4) != 0, d & 16'h7F7F | (d & 16'h8080),
                 ($urandom % 4) == 0, "R2 R12 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule